// File: doc/BRIEF.md
# Wired Interrupt Source Gateway

This block keeps the per-source state that sits between a set of wired interrupt lines and a message-signalled interrupt domain. It serves `NSRC` sources numbered 1 to `NSRC`; number 0 is reserved and never exists. Each source has a stored detection mode, a pending flag, an enable flag and a register holding the input level sampled on the previous clock. Every clock, every source samples its wire in parallel and raises pending according to its mode: on a rising edge, on a falling edge, or at a high or low level.

Software reaches the same state through three request ports. The configuration port writes a mode and reads it back. The pending port sets or clears one source's pending flag. The enable port sets or clears one source's enable flag. Each request names a single source and completes in one clock. Register decoding and message generation belong to the surrounding logic, which reads the pending, enable and corrected-input vectors directly.

All request ports are plain strobes with no back-pressure: the block can always take a request, so there is no ready signal and a strobe is acted on in the cycle it is seen. The per-source outputs are registered state that changes only on a clock edge.

Top module: `source_gateway`

## Requirements
- R1: A request naming source 0, or a number greater than `NSRC`, changes nothing. A configuration read of such a number returns 0. Output bit 0 of every vector is always 0.
- R2: A configuration write whose data bit 10 is 1 stores mode 0. Otherwise the block stores data bits 2:0 as the mode. A read returns the stored mode in bits 2:0 with all other bits 0. Mode encodings are 0 = inactive, 4 = rising edge, 5 = falling edge, 6 = level high and 7 = level low.
- R3: In mode 4, pending becomes 1 when the sampled level is 1 and the stored previous level is 0. In mode 5, pending becomes 1 when the sampled level is 0 and the stored previous level is 1.
- R4: In mode 6, pending becomes 1 in every cycle the sampled level is 1. In mode 7, pending becomes 1 in every cycle the sampled level is 0.
- R5: Every source stores its wire level on every clock, whatever its mode. Detection always compares against the level stored on the previous clock.
- R6: In mode 0, and in the unused modes 1 to 3, a source detects nothing and ignores software set and clear of pending.
- R7: On a source in mode 6, a software set of pending takes effect only while the stored level is 1. In mode 7, it takes effect only while the stored level is 0. A software clear on a mode 6 or mode 7 source is ignored. In modes 4 and 5, a software set or clear always takes effect.
- R8: A software enable set or clear on a valid source takes effect on the next clock, in any mode.
- R9: The reported input of a source is its stored level, inverted in modes 5 and 7. It is 0 in modes 0 to 3.
- R10: When hardware detection and a software clear hit the same source in the same cycle, pending ends at 1. A mode written in a cycle governs detection from the next cycle on.
- R11: After reset, all modes, pending flags, enable flags and stored levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_level_i | input | NSRC+1 | Raw wire level per source; bit 0 is unused |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_id_i | input | IDW | Source number for the configuration write |
| cfg_wdata_i | input | 32 | Configuration write data (bit 10 delegate flag, bits 2:0 mode) |
| cfg_rid_i | input | IDW | Source number for the configuration read |
| cfg_rdata_o | output | 32 | Stored mode of the source named by `cfg_rid_i` |
| ip_req_i | input | 1 | Pending request strobe |
| ip_set_i | input | 1 | 1 = set pending, 0 = clear pending |
| ip_id_i | input | IDW | Source number for the pending request |
| ie_req_i | input | 1 | Enable request strobe |
| ie_set_i | input | 1 | 1 = set enable, 0 = clear enable |
| ie_id_i | input | IDW | Source number for the enable request |
| pend_o | output | NSRC+1 | Pending flags; bit 0 is 0 |
| en_o | output | NSRC+1 | Enable flags; bit 0 is 0 |
| in_o | output | NSRC+1 | Mode-corrected input level; bit 0 is 0 |

## Verification
A corrupted stored level first shows on `in_o` at the very next sample, because the corrected input is that level read directly. It also shows as a spurious or missing edge detection in `pend_o` one clock later. A wrong stored mode shows at once on `cfg_rdata_o`, and within a cycle as a wrong polarity on `in_o` or a wrong pending reaction. Pending and enable are visible ports themselves, so any mistake in their update logic appears on the clock edge where it happens. The bench therefore compares all four outputs against a behavioural model after every edge.

// File: rtl/srcgw_pkg.sv
package srcgw_pkg;

  localparam int MODE_W      = 3;
  localparam int CFG_W       = 32;
  localparam int DLG_BIT     = 10;

  localparam logic [MODE_W-1:0] SM_OFF  = 3'd0;
  localparam logic [MODE_W-1:0] SM_RISE = 3'd4;
  localparam logic [MODE_W-1:0] SM_FALL = 3'd5;
  localparam logic [MODE_W-1:0] SM_HIGH = 3'd6;
  localparam logic [MODE_W-1:0] SM_LOW  = 3'd7;

  // Modes 4..7 share bit 2; 6/7 add bit 1; inverted polarity has bit 0
  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    return m[2];
  endfunction

  function automatic logic mode_level(input logic [MODE_W-1:0] m);
    return m[2] & m[1];
  endfunction

  function automatic logic mode_inverted(input logic [MODE_W-1:0] m);
    return m[2] & m[0];
  endfunction

  function automatic logic [MODE_W-1:0] cfg_clean(input logic [CFG_W-1:0] w);
    return w[DLG_BIT] ? SM_OFF : w[MODE_W-1:0];
  endfunction

endpackage

// File: rtl/srcgw_id_dec.sv
module srcgw_id_dec #(
  parameter int NSRC = 12,
  parameter int IDW  = 5
) (
  input  logic            req_i,
  input  logic [IDW-1:0]  id_i,
  output logic [NSRC:1]   hit_o
);

  // Source 0 and numbers above NSRC never match any slot
  for (genvar s = 1; s <= NSRC; s++) begin : g_hit
    assign hit_o[s] = req_i && (id_i == IDW'(s));
  end

endmodule

// File: rtl/srcgw_cell.sv
module srcgw_cell
  import srcgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              level_i,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic              ip_set_i,
  input  logic              ip_clr_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              pend_o,
  output logic              en_o,
  output logic              in_o
);

  logic [MODE_W-1:0] mode_q;
  logic              lat_q;
  logic              pend_q;
  logic              en_q;

  logic hw_hit;
  logic sw_set_ok;
  logic sw_clr_ok;
  logic pend_d;

  always_comb begin
    unique case (mode_q)
      SM_RISE: hw_hit = level_i & ~lat_q;
      SM_FALL: hw_hit = ~level_i & lat_q;
      SM_HIGH: hw_hit = level_i;
      SM_LOW:  hw_hit = ~level_i;
      default: hw_hit = 1'b0;
    endcase
  end

  // Level sources accept a set only while the old sample sits at its asserted level
  always_comb begin
    sw_set_ok = ip_set_i & mode_active(mode_q);
    sw_clr_ok = ip_clr_i & mode_active(mode_q) & ~mode_level(mode_q);
    if (mode_level(mode_q) && (lat_q == mode_inverted(mode_q)))
      sw_set_ok = 1'b0;
  end

  assign pend_d = hw_hit | sw_set_ok | (pend_q & ~sw_clr_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SM_OFF;
      lat_q  <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      lat_q  <= level_i;
      pend_q <= pend_d;
      if (cfg_we_i) mode_q <= cfg_mode_i;
      if (ie_set_i)      en_q <= 1'b1;
      else if (ie_clr_i) en_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign in_o   = mode_active(mode_q) & (lat_q ^ mode_inverted(mode_q));

endmodule

// File: rtl/source_gateway.sv
module source_gateway
  import srcgw_pkg::*;
#(
  parameter int NSRC = 12,
  parameter int IDW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC:0]    src_level_i,
  input  logic             cfg_we_i,
  input  logic [IDW-1:0]   cfg_id_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic [IDW-1:0]   cfg_rid_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic             ip_req_i,
  input  logic             ip_set_i,
  input  logic [IDW-1:0]   ip_id_i,
  input  logic             ie_req_i,
  input  logic             ie_set_i,
  input  logic [IDW-1:0]   ie_id_i,
  output logic [NSRC:0]    pend_o,
  output logic [NSRC:0]    en_o,
  output logic [NSRC:0]    in_o
);

  logic [NSRC:1]              cfg_hit;
  logic [NSRC:1]              ip_hit;
  logic [NSRC:1]              ie_hit;
  logic [NSRC:0][MODE_W-1:0]  mode_w;
  logic [MODE_W-1:0]          cfg_mode;
  logic                       unused_bits;

  assign cfg_mode    = cfg_clean(cfg_wdata_i);
  assign unused_bits = ^{cfg_wdata_i, src_level_i[0]};

  srcgw_id_dec #(.NSRC(NSRC), .IDW(IDW)) u_cfg_dec (
    .req_i(cfg_we_i), .id_i(cfg_id_i), .hit_o(cfg_hit));
  srcgw_id_dec #(.NSRC(NSRC), .IDW(IDW)) u_ip_dec (
    .req_i(ip_req_i), .id_i(ip_id_i), .hit_o(ip_hit));
  srcgw_id_dec #(.NSRC(NSRC), .IDW(IDW)) u_ie_dec (
    .req_i(ie_req_i), .id_i(ie_id_i), .hit_o(ie_hit));

  assign mode_w[0] = SM_OFF;
  assign pend_o[0] = 1'b0;
  assign en_o[0]   = 1'b0;
  assign in_o[0]   = 1'b0;

  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    srcgw_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_i   (src_level_i[s]),
      .cfg_we_i  (cfg_hit[s]),
      .cfg_mode_i(cfg_mode),
      .ip_set_i  (ip_hit[s] & ip_set_i),
      .ip_clr_i  (ip_hit[s] & ~ip_set_i),
      .ie_set_i  (ie_hit[s] & ie_set_i),
      .ie_clr_i  (ie_hit[s] & ~ie_set_i),
      .mode_o    (mode_w[s]),
      .pend_o    (pend_o[s]),
      .en_o      (en_o[s]),
      .in_o      (in_o[s])
    );
  end

  // Read mux: unknown numbers fall through to zero
  always_comb begin
    cfg_rdata_o = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (cfg_rid_i == IDW'(s)) cfg_rdata_o[MODE_W-1:0] = mode_w[s];
    end
  end

endmodule

// File: rtl/srcgw_chk.sv
module srcgw_chk #(
  parameter int NSRC = 12,
  parameter int IDW  = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSRC:0]        src_level_i,
  input logic                 cfg_we_i,
  input logic                 ip_req_i,
  input logic                 ie_req_i,
  input logic                 ie_set_i,
  input logic [IDW-1:0]       ie_id_i,
  input logic [NSRC:0]        pend_o,
  input logic [NSRC:0]        en_o,
  input logic [NSRC:0]        in_o,
  input logic [NSRC:0][2:0]   mode_w
);

  AST_BAD_ID_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_req_i && (ie_id_i == '0 || int'(ie_id_i) > NSRC)) |=> $stable(en_o)); // R1

  for (genvar s = 1; s <= NSRC; s++) begin : g_chk
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w[s] == 3'd4 && src_level_i[s] && !in_o[s]) |=> pend_o[s]); // R3

    AST_HIGH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w[s] == 3'd6 && src_level_i[s]) |=> pend_o[s]); // R4

    AST_LATCH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w[s] == 3'd4 && !cfg_we_i) |=> (in_o[s] == $past(src_level_i[s]))); // R5

    AST_OFF_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w[s] == 3'd0 && !pend_o[s]) |=> !pend_o[s]); // R6

    AST_LEVEL_SET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w[s] == 3'd6 && !in_o[s] && !src_level_i[s] && !pend_o[s]) |=> !pend_o[s]); // R7

    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_req_i && ie_set_i && ie_id_i == IDW'(s)) |=> en_o[s]); // R8

    AST_OFF_INPUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_w[s][2]) |-> !in_o[s]); // R9
  end

endmodule

bind source_gateway srcgw_chk #(.NSRC(NSRC), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_level_i(src_level_i), .cfg_we_i(cfg_we_i),
  .ip_req_i(ip_req_i), .ie_req_i(ie_req_i), .ie_set_i(ie_set_i), .ie_id_i(ie_id_i),
  .pend_o(pend_o), .en_o(en_o), .in_o(in_o), .mode_w(mode_w));

// File: tb/sim_source_gateway.sv
module sim_source_gateway;
  localparam int NSRC = 12;
  localparam int IDW  = 5;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC:0] lvl = '0;
  logic cfg_we = 0; logic [IDW-1:0] cfg_id = '0; logic [31:0] cfg_wdata = '0;
  logic [IDW-1:0] cfg_rid = '0; logic [31:0] cfg_rdata;
  logic ip_req = 0, ip_set = 0; logic [IDW-1:0] ip_id = '0;
  logic ie_req = 0, ie_set = 0; logic [IDW-1:0] ie_id = '0;
  logic [NSRC:0] pend, en, inp;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R11";
  bit done = 0;

  int m_mode [NSRC+1];
  int m_lat  [NSRC+1];
  int m_pend [NSRC+1];
  int m_en   [NSRC+1];

  always #(CLK_PERIOD/2) clk = ~clk;

  source_gateway #(.NSRC(NSRC), .IDW(IDW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_level_i(lvl),
    .cfg_we_i(cfg_we), .cfg_id_i(cfg_id), .cfg_wdata_i(cfg_wdata),
    .cfg_rid_i(cfg_rid), .cfg_rdata_o(cfg_rdata),
    .ip_req_i(ip_req), .ip_set_i(ip_set), .ip_id_i(ip_id),
    .ie_req_i(ie_req), .ie_set_i(ie_set), .ie_id_i(ie_id),
    .pend_o(pend), .en_o(en), .in_o(inp));

  task automatic compare();
    logic [NSRC:0] ep, ee, ei;
    logic [31:0] er;
    ep = '0; ee = '0; ei = '0; er = '0;
    for (int s = 1; s <= NSRC; s++) begin
      ep[s] = (m_pend[s] != 0);
      ee[s] = (m_en[s] != 0);
      if (m_mode[s] >= 4)
        ei[s] = ((m_lat[s] != 0) ^ (m_mode[s] == 5 || m_mode[s] == 7));
    end
    if (int'(cfg_rid) >= 1 && int'(cfg_rid) <= NSRC) er = 32'(m_mode[cfg_rid]);
    n_cmp += 4;
    if (pend !== ep) begin n_bad++; $display("FAIL %s pending got %h expected %h", cur_req, pend, ep); end
    if (en !== ee)   begin n_bad++; $display("FAIL %s enable got %h expected %h", cur_req, en, ee); end
    if (inp !== ei)  begin n_bad++; $display("FAIL %s input got %h expected %h", cur_req, inp, ei); end
    if (cfg_rdata !== er) begin n_bad++; $display("FAIL %s config read got %h expected %h", cur_req, cfg_rdata, er); end
  endtask

  // Advance the model by one clock from the inputs now driven, then check
  task automatic cycle();
    for (int s = 1; s <= NSRC; s++) begin
      int m, l, lv, hw, ss, sc;
      m = m_mode[s]; l = m_lat[s]; lv = lvl[s];
      hw = 0;
      if (m == 4) hw = (lv == 1 && l == 0);
      if (m == 5) hw = (lv == 0 && l == 1);
      if (m == 6) hw = (lv == 1);
      if (m == 7) hw = (lv == 0);
      ss = (ip_req && int'(ip_id) == s && ip_set);
      sc = (ip_req && int'(ip_id) == s && !ip_set);
      if (m < 4) begin ss = 0; sc = 0; end
      if (m >= 6) begin
        sc = 0;
        if (m == 6 && l == 0) ss = 0;
        if (m == 7 && l == 1) ss = 0;
      end
      m_pend[s] = (hw != 0 || ss != 0 || (m_pend[s] != 0 && sc == 0)) ? 1 : 0;
      if (ie_req && int'(ie_id) == s) m_en[s] = ie_set;
      m_lat[s] = lv;
      if (cfg_we && int'(cfg_id) == s) m_mode[s] = cfg_wdata[10] ? 0 : int'(cfg_wdata[2:0]);
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    cfg_we = 0; ip_req = 0; ie_req = 0;
  endtask

  task automatic wcfg(input int id, input logic [31:0] d);
    idle(); cfg_we = 1; cfg_id = IDW'(id); cfg_wdata = d; cfg_rid = IDW'(id);
    cycle(); idle();
  endtask

  task automatic sw_ip(input int id, input bit set);
    idle(); ip_req = 1; ip_id = IDW'(id); ip_set = set; cycle(); idle();
  endtask

  task automatic sw_ie(input int id, input bit set);
    idle(); ie_req = 1; ie_id = IDW'(id); ie_set = set; cycle(); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s <= NSRC; s++) begin m_mode[s] = 0; m_lat[s] = 0; m_pend[s] = 0; m_en[s] = 0; end
    repeat (3) @(negedge clk);
    cur_req = "R11"; compare();
    rst_n = 1;
    cycle();

    cur_req = "R2";
    wcfg(1, 32'h4); wcfg(2, 32'h5); wcfg(3, 32'h6); wcfg(4, 32'h7);
    wcfg(5, 32'h406);            // delegate bit: stores 0
    wcfg(6, 32'h7FF);            // delegate bit: stores 0
    wcfg(7, 32'hFFFF_FBF4);      // bit 10 clear: mode 4 kept
    wcfg(8, 32'h3);              // unused mode value kept
    cycle();

    cur_req = "R1";
    wcfg(0, 32'h4); wcfg(13, 32'h6); wcfg(31, 32'h7);
    sw_ie(0, 1); sw_ie(20, 1); sw_ip(0, 1); sw_ip(15, 1);
    cfg_rid = 0; cycle(); cfg_rid = 13; cycle();

    cur_req = "R8";
    sw_ie(5, 1); sw_ie(1, 1); sw_ie(12, 1); sw_ie(1, 0); cycle();

    cur_req = "R3";
    lvl[1] = 1; lvl[2] = 1; cycle(); cycle();
    sw_ip(1, 0); lvl[2] = 0; cycle(); cycle(); sw_ip(2, 0);

    cur_req = "R5";
    lvl[6] = 1; lvl[8] = 1; cycle(); lvl[7] = 1; cycle(); lvl[7] = 0; cycle();

    cur_req = "R6";
    sw_ip(5, 1); sw_ip(8, 1); sw_ip(6, 0);

    cur_req = "R7";
    lvl[3] = 0; lvl[4] = 1; cycle();
    sw_ip(3, 1); sw_ip(4, 1);
    lvl[3] = 1; cycle();
    lvl[3] = 0; idle(); ip_req = 1; ip_id = 3; ip_set = 1; cycle(); idle();
    sw_ip(3, 0);
    sw_ip(1, 1); sw_ip(1, 0);

    cur_req = "R10";
    sw_ip(7, 1);
    lvl[7] = 1; idle(); ip_req = 1; ip_id = 7; ip_set = 0; cycle(); idle();
    cfg_we = 1; cfg_id = 9; cfg_wdata = 32'h6; cfg_rid = 9; lvl[9] = 1; cycle(); idle(); cycle();

    cur_req = "R9";
    for (int k = 0; k < 3000; k++) begin
      lvl = {$urandom(), 1'b0} & {NSRC+1{1'b1}};
      lvl[0] = 0;
      cfg_we  = ($urandom_range(0, 5) == 0);
      cfg_id  = IDW'($urandom_range(0, 14));
      cfg_wdata = {$urandom()} & 32'h0000_0407;
      if ($urandom_range(0, 1) == 0) cfg_wdata[10] = 0;
      cfg_rid = IDW'($urandom_range(0, 14));
      ip_req = ($urandom_range(0, 1) == 0); ip_set = 1'($urandom_range(0, 1));
      ip_id  = IDW'($urandom_range(0, 14));
      ie_req = ($urandom_range(0, 2) == 0); ie_set = 1'($urandom_range(0, 1));
      ie_id  = IDW'($urandom_range(0, 14));
      cycle();
    end
    idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule